// File: doc/BRIEF.md
# Calendar Date Counter

This block keeps the calendar date for a clock section. It holds the day of the month, the month and a two-digit year, each as a packed BCD byte. A single-cycle pulse from the time-of-day logic, one per day, moves the date forward. The block works out when the day, month and year roll over, using the correct length for each month and a 29-day February in leap years.

A year counts as a leap year when its two-digit value is divisible by four. Year 00 is always a leap year, because the century exception is never applied. A host can load any of the three fields with a synchronous write strobe, and the current fields can be read at all times on dedicated read ports. A write in the same cycle as a day pulse takes priority over the pulse.

Top module: `cal_date_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the date becomes day 01, month 01, year 00 (BCD 8'h01, 8'h01, 8'h00).
- R2: Each field is packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. A day pulse with no write adds one to the day before its month's last day (for example 8'h09 goes to 8'h10) and leaves the month and year unchanged.
- R3: Months 01, 03, 05, 07, 08, 10 and 12 end on day 31. A pulse on day 31 sets the day to 01 and moves the month forward by one.
- R4: Months 04, 06, 09 and 11 end on day 30. A pulse on day 30 sets the day to 01 and moves the month forward by one.
- R5: In a year whose two-digit value is not divisible by four, February ends on day 28. A pulse on 28-02 gives 01-03.
- R6: In a year whose two-digit value is divisible by four, February ends on day 29. This includes year 00, which is always a leap year. A pulse on 28-02 gives 29-02, and a pulse on 29-02 gives 01-03.
- R7: A month rollover from 12 sets the month to 01 and moves the year forward by one. The year runs from 00 to 99 and wraps from 99 to 00.
- R8: A write strobe loads its field at the next clock edge. If any write strobe is high, a day pulse in the same cycle has no effect on any field, and fields that are not written keep their values.
- R9: With no day pulse and no write strobe, all three fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| day_tick | input | 1 | One-cycle pulse once per day |
| wr_day | input | 1 | Load strobe for the day field |
| wr_day_val | input | 8 | BCD day value to load |
| wr_mon | input | 1 | Load strobe for the month field |
| wr_mon_val | input | 8 | BCD month value to load |
| wr_year | input | 1 | Load strobe for the year field |
| wr_year_val | input | 8 | BCD year value to load |
| rd_day | output | 8 | Current day of month, BCD |
| rd_mon | output | 8 | Current month, BCD |
| rd_year | output | 8 | Current two-digit year, BCD |

## Verification
The read ports are the stored registers themselves. A wrong digit, a missed carry or a wrong month length therefore shows on a read port in the cycle right after the faulty edge. The bench compares all three fields against a behavioural date model after every clock. A wrong leap decision shows only at the end of February, and a wrong year carry shows only at the end of December. The long pulse runs therefore cross several year ends, the 99-to-00 wrap, and February in years from both leap-test branches (tens digit even and tens digit odd).

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int BCD_W = 8;

    typedef logic [BCD_W-1:0] bcd8_t;

    typedef struct packed {
        bcd8_t year;
        bcd8_t month;
        bcd8_t day;
    } cal_date_t;

    typedef enum logic [1:0] {
        MLEN_28 = 2'd0,
        MLEN_29 = 2'd1,
        MLEN_30 = 2'd2,
        MLEN_31 = 2'd3
    } mlen_e;

    localparam bcd8_t DAY_FIRST   = 8'h01;
    localparam bcd8_t MON_FIRST   = 8'h01;
    localparam bcd8_t MON_LAST    = 8'h12;
    localparam bcd8_t YEAR_FIRST  = 8'h00;
    localparam bcd8_t YEAR_LAST   = 8'h99;

    localparam cal_date_t DATE_RESET = '{year: YEAR_FIRST, month: MON_FIRST, day: DAY_FIRST};

    // Add one to a packed two-digit BCD value (99 yields 00).
    function automatic bcd8_t bcd_inc(input bcd8_t v);
        bcd8_t r;
        if (v[3:0] >= 4'd9) begin
            r[3:0] = 4'd0;
            r[7:4] = (v[7:4] >= 4'd9) ? 4'd0 : v[7:4] + 4'd1;
        end else begin
            r[3:0] = v[3:0] + 4'd1;
            r[7:4] = v[7:4];
        end
        return r;
    endfunction

    // 10*t + u is divisible by 4 exactly when 2*t + u is: even tens need
    // units 0/4/8, odd tens need units 2/6.
    function automatic logic bcd_div4(input bcd8_t y);
        logic r;
        if (y[4] == 1'b0)
            r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        else
            r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return r;
    endfunction

    function automatic bcd8_t mlen_last_day(input mlen_e l);
        bcd8_t r;
        case (l)
            MLEN_28: r = 8'h28;
            MLEN_29: r = 8'h29;
            MLEN_30: r = 8'h30;
            default: r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cal_leap_detect.sv
module cal_leap_detect
    import cal_pkg::*;
(
    input  bcd8_t year_i,
    output logic  leap_o
);
    // Century exception intentionally absent: year 00 is always leap.
    always_comb begin
        leap_o = bcd_div4(year_i);
    end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
    import cal_pkg::*;
(
    input  bcd8_t month_i,
    input  logic  leap_i,
    output mlen_e len_o
);
    always_comb begin
        case (month_i)
            8'h02:                      len_o = leap_i ? MLEN_29 : MLEN_28;
            8'h04, 8'h06, 8'h09, 8'h11: len_o = MLEN_30;
            default:                    len_o = MLEN_31;
        endcase
    end
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
    import cal_pkg::*;
#(
    parameter bcd8_t RESET_VAL = 8'h01,
    parameter bcd8_t WRAP_VAL  = 8'h01
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  bcd8_t load_val_i,
    input  logic  step_i,
    input  logic  last_i,
    output bcd8_t value_o,
    output logic  carry_o
);
    bcd8_t value_q;

    always_ff @(posedge clk) begin
        if (rst)
            value_q <= RESET_VAL;
        else if (load_i)
            value_q <= load_val_i;
        else if (step_i)
            value_q <= last_i ? WRAP_VAL : bcd_inc(value_q);
    end

    assign value_o = value_q;
    assign carry_o = step_i & last_i;
endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       day_tick,
    input  logic       wr_day,
    input  logic [7:0] wr_day_val,
    input  logic       wr_mon,
    input  logic [7:0] wr_mon_val,
    input  logic       wr_year,
    input  logic [7:0] wr_year_val,
    output logic [7:0] rd_day,
    output logic [7:0] rd_mon,
    output logic [7:0] rd_year
);
    cal_date_t cur;
    cal_date_t wr_val;
    logic      any_wr;
    logic      adv;
    logic      leap;
    mlen_e     mlen;
    bcd8_t     last_day;
    logic      day_end, mon_end, year_end;
    logic      day_carry, mon_carry, year_carry;

    assign wr_val = '{year: wr_year_val, month: wr_mon_val, day: wr_day_val};
    assign any_wr = wr_day | wr_mon | wr_year;
    assign adv    = day_tick & ~any_wr;

    cal_leap_detect u_leap (
        .year_i (cur.year),
        .leap_o (leap)
    );

    cal_month_len u_mlen (
        .month_i (cur.month),
        .leap_i  (leap),
        .len_o   (mlen)
    );

    assign last_day = mlen_last_day(mlen);
    // At-or-beyond compare so an out-of-range host write still rolls over.
    assign day_end  = (cur.day   >= last_day);
    assign mon_end  = (cur.month >= MON_LAST);
    assign year_end = (cur.year  >= YEAR_LAST);

    cal_bcd_field #(.RESET_VAL(DATE_RESET.day), .WRAP_VAL(DAY_FIRST)) u_day (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wr_day),
        .load_val_i (wr_val.day),
        .step_i     (adv),
        .last_i     (day_end),
        .value_o    (cur.day),
        .carry_o    (day_carry)
    );

    cal_bcd_field #(.RESET_VAL(DATE_RESET.month), .WRAP_VAL(MON_FIRST)) u_mon (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wr_mon),
        .load_val_i (wr_val.month),
        .step_i     (day_carry),
        .last_i     (mon_end),
        .value_o    (cur.month),
        .carry_o    (mon_carry)
    );

    cal_bcd_field #(.RESET_VAL(DATE_RESET.year), .WRAP_VAL(YEAR_FIRST)) u_year (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wr_year),
        .load_val_i (wr_val.year),
        .step_i     (mon_carry),
        .last_i     (year_end),
        .value_o    (cur.year),
        .carry_o    (year_carry)
    );

    assign rd_day  = cur.day;
    assign rd_mon  = cur.month;
    assign rd_year = cur.year;

    logic unused_ok;
    assign unused_ok = year_carry;
endmodule

// File: rtl/cal_date_counter_chk.sv
module cal_date_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       day_tick,
    input logic       wr_day,
    input logic [7:0] wr_day_val,
    input logic       wr_mon,
    input logic [7:0] wr_mon_val,
    input logic       wr_year,
    input logic [7:0] wr_year_val,
    input logic [7:0] rd_day,
    input logic [7:0] rd_mon,
    input logic [7:0] rd_year
);
    logic any_wr;
    logic adv;
    assign any_wr = wr_day | wr_mon | wr_year;
    assign adv    = day_tick & ~any_wr;

    p_reset_date_r1: assert property (@(posedge clk)
        rst |=> (rd_day == 8'h01 && rd_mon == 8'h01 && rd_year == 8'h00));

    p_mid_month_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && rd_day < 8'h28) |=> ($stable(rd_mon) && $stable(rd_year) && rd_day != $past(rd_day)));

    p_long_month_end_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && rd_day == 8'h31 && rd_mon == 8'h07) |=> (rd_day == 8'h01 && rd_mon == 8'h08));

    p_short_month_end_r4: assert property (@(posedge clk) disable iff (rst)
        (adv && rd_day == 8'h30 && rd_mon == 8'h09) |=> (rd_day == 8'h01 && rd_mon == 8'h10));

    p_feb_leap_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && rd_day == 8'h28 && rd_mon == 8'h02 && rd_year == 8'h00) |=> (rd_day == 8'h29 && rd_mon == 8'h02));

    p_year_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (adv && rd_day == 8'h31 && rd_mon == 8'h12 && rd_year == 8'h99)
        |=> (rd_day == 8'h01 && rd_mon == 8'h01 && rd_year == 8'h00));

    p_write_day_r8: assert property (@(posedge clk) disable iff (rst)
        wr_day |=> (rd_day == $past(wr_day_val)));

    p_write_mon_r8: assert property (@(posedge clk) disable iff (rst)
        wr_mon |=> (rd_mon == $past(wr_mon_val)));

    p_write_year_r8: assert property (@(posedge clk) disable iff (rst)
        wr_year |=> (rd_year == $past(wr_year_val)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!day_tick && !any_wr) |=> ($stable(rd_day) && $stable(rd_mon) && $stable(rd_year)));
endmodule

bind cal_date_counter cal_date_counter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .day_tick    (day_tick),
    .wr_day      (wr_day),
    .wr_day_val  (wr_day_val),
    .wr_mon      (wr_mon),
    .wr_mon_val  (wr_mon_val),
    .wr_year     (wr_year),
    .wr_year_val (wr_year_val),
    .rd_day      (rd_day),
    .rd_mon      (rd_mon),
    .rd_year     (rd_year)
);

// File: tb/cal_date_counter_tb.sv
module cal_date_counter_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       day_tick;
    logic       wr_day, wr_mon, wr_year;
    logic [7:0] wr_day_val, wr_mon_val, wr_year_val;
    logic [7:0] rd_day, rd_mon, rd_year;

    int n_chk = 0;
    int n_bad = 0;
    int md, mm, my;
    string tag;

    always #10 clk = ~clk;

    cal_date_counter u_dut (
        .clk (clk), .rst (rst), .day_tick (day_tick),
        .wr_day (wr_day), .wr_day_val (wr_day_val),
        .wr_mon (wr_mon), .wr_mon_val (wr_mon_val),
        .wr_year (wr_year), .wr_year_val (wr_year_val),
        .rd_day (rd_day), .rd_mon (rd_mon), .rd_year (rd_year)
    );

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int days_in(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic cmp(input string req, input string fld, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h (model %0d-%0d-%0d)", req, fld, act, exp, md, mm, my);
        end
    endtask

    task automatic check_all();
        cmp(tag, "day",  rd_day,  i2b(md));
        cmp(tag, "mon",  rd_mon,  i2b(mm));
        cmp(tag, "year", rd_year, i2b(my));
    endtask

    // Called at a falling edge: drive, update model, then compare after the next rising edge.
    task automatic cycle(input logic t, input logic wd, input int dv, input logic wm, input int mv,
                         input logic wy, input int yv);
        day_tick = t;
        wr_day = wd;  wr_day_val  = i2b(dv);
        wr_mon = wm;  wr_mon_val  = i2b(mv);
        wr_year = wy; wr_year_val = i2b(yv);
        if (wd || wm || wy) begin
            tag = "R8";
            if (wd) md = dv;
            if (wm) mm = mv;
            if (wy) my = yv;
        end else if (!t) begin
            tag = "R9";
        end else if (md < days_in(mm, my)) begin
            tag = "R2";
            md++;
        end else begin
            if (mm == 12) tag = "R7";
            else if (mm == 2) tag = (my % 4 == 0) ? "R6" : "R5";
            else if (days_in(mm, my) == 30) tag = "R4";
            else tag = "R3";
            md = 1;
            if (mm == 12) begin
                mm = 1;
                my = (my + 1) % 100;
            end else begin
                mm++;
            end
        end
        if (t && tag == "R2" && md == 29 && mm == 2) tag = "R6";
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 1, 1'b0, 1, 1'b0, 0);
    endtask

    task automatic set_date(input int d, input int m, input int y);
        cycle(1'b0, 1'b1, d, 1'b1, m, 1'b1, y);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        day_tick = 1'b0;
        wr_day = 1'b0; wr_mon = 1'b0; wr_year = 1'b0;
        wr_day_val = 8'h00; wr_mon_val = 8'h00; wr_year_val = 8'h00;
        md = 1; mm = 1; my = 0;
        repeat (3) @(negedge clk);
        tag = "R1";
        check_all();
        // Reset wins over a pending pulse.
        day_tick = 1'b1;
        @(negedge clk);
        check_all();
        day_tick = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        tag = "R9";
        check_all();

        // Long run from reset: years 00..04 (leap year 00 and 04, plain 01..03).
        ticks(1500);

        // Across the 99 -> 00 wrap.
        set_date(25, 12, 98);
        ticks(800);

        // February in several years, both leap-test branches.
        for (int k = 0; k < 10; k++) begin
            set_date(27, 2, 10 + 2 * k + (k > 5 ? 60 : 0));
            ticks(3);
        end
        set_date(27, 2, 0);
        ticks(3);

        // Thirty-day months and month-end cases.
        set_date(29, 4, 21);  ticks(3);
        set_date(29, 11, 21); ticks(3);
        set_date(30, 8, 21);  ticks(3);

        // Write together with a pulse: the pulse is dropped.
        set_date(31, 12, 45);
        cycle(1'b1, 1'b1, 15, 1'b0, 1, 1'b0, 0);
        cycle(1'b1, 1'b0, 1, 1'b1, 3, 1'b0, 0);
        cycle(1'b1, 1'b0, 1, 1'b0, 1, 1'b1, 77);
        ticks(2);

        // Idle and sparse pulses.
        for (int i = 0; i < 400; i++) cycle((i % 3) == 0, 1'b0, 1, 1'b0, 1, 1'b0, 0);

        day_tick = 1'b0;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule